// File: doc/BRIEF.md
# Erase Pin Hold Filter and Nonvolatile Bit Reinitialisation

This block watches an asynchronous erase request pin from a slow RC clock domain. The pin is first brought through a synchroniser. A hold counter then measures how long the pin has stayed high. Short glitches are discarded. Only a hold that reaches a parameterised threshold (about 220 ms at the RC rate) starts a reinitialisation. The counter restarts whenever the pin falls low, so separate pulses never add up.

A qualified hold raises a full-array erase request toward the flash array. The array is modelled here only by a done handshake. When done arrives, the block clears every region lock bit, the security bit and all general-purpose nonvolatile bits in the same edge:
- bit 0 enables the brownout detector;
- bit 1 enables the brownout reset;
- bit 2 selects boot from flash, so a cleared bit 2 means boot from ROM.

The calibration bits are never altered. The block does not fire again until the pin has gone low and a new full hold has been seen.

A small command port lets software set or clear lock bits and general-purpose bits, and set the security bit. The security bit can be cleared in one way only: by completing the pin-driven erase.

Top module: `erase_nvm_ctrl`

## Requirements
- R1: A pin high level seen on fewer than TRIG_CYCLES consecutive rising clock edges never raises `erase_req`. This covers every pulse shorter than IGNORE_CYCLES.
- R2: A pin held high for TRIG_CYCLES consecutive sampling edges raises `erase_req` visible after edge TRIG_CYCLES+2, counted from the first edge that samples the pin high. `erase_req` then stays high until `erase_done` is seen.
- R3: A low level on the pin for even one sampling edge restarts the hold count. Two holds of TRIG_CYCLES-2 edges split by one low edge do not trigger.
- R4: On the edge where `erase_done` is high while `erase_req` is high, all `lock_bits` become 0 and all `gpnvm_bits` become 0, and `erase_req` falls. In `gpnvm_bits`, bit 0 is brownout detector enable, bit 1 is brownout reset enable and bit 2 is boot from flash.
- R5: The security bit is set by command op 5 one edge after the command. Command op 6 (clear security) has no effect. The security bit falls only on erase completion.
- R6: `calib_bits` always equal the parameter CAL_INIT, including after an erase.
- R7: After an erase completes with the pin still high, no new request is raised until the pin has been low and then held high again for a full TRIG_CYCLES hold.
- R8: Command encoding on `cmd_op` with `cmd_valid`:
  - 1 sets lock bit `cmd_idx`;
  - 2 clears lock bit `cmd_idx`;
  - 3 sets general-purpose bit `cmd_idx`;
  - 4 clears general-purpose bit `cmd_idx`;
  - 0 does nothing.
  Each command takes effect on the next rising edge. An index outside a vector's width has no effect on that vector.
- R9: Commands issued while `erase_req` is high have no effect.
- R10: `erase_done` while `erase_req` is low has no effect on any bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow RC oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| erase_pin | input | 1 | Asynchronous erase request pin, active high |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code (see R5, R8) |
| cmd_idx | input | IDX_W | Bit index for lock and general-purpose commands |
| erase_done | input | 1 | Full-array erase finished handshake |
| erase_req | output | 1 | Full-array erase request, held until done |
| lock_bits | output | N_LOCK | Region lock bits, 1 = locked |
| gpnvm_bits | output | N_GPNVM | General-purpose nonvolatile bits |
| security | output | 1 | Security bit |
| calib_bits | output | N_CAL | Calibration bits, never written |

## Verification
The pin path has a fixed latency: two synchroniser edges, then TRIG_CYCLES-1 counting edges, then the state register. So the request is due exactly TRIG_CYCLES+2 edges after the first sampling edge. The bench sweeps hold lengths from 1 to TRIG_CYCLES+2 and records the edge at which the request first appears, sampling at falling edges. Commands and the done handshake act on the very next rising edge. Each one is driven at a falling edge, and its result is read at the following falling edge.

// File: rtl/erase_pkg.sv
package erase_pkg;
   typedef enum logic [2:0] {
      OP_NOP     = 3'd0,
      OP_LOCK_SET = 3'd1,
      OP_LOCK_CLR = 3'd2,
      OP_GP_SET  = 3'd3,
      OP_GP_CLR  = 3'd4,
      OP_SEC_SET = 3'd5,
      OP_SEC_CLR = 3'd6
   } nvm_op_e;

   typedef enum logic [1:0] {
      ST_IDLE     = 2'd0,
      ST_REQ      = 2'd1,
      ST_WAIT_LOW = 2'd2
   } erase_state_e;

   function automatic int max_of(input int a, input int b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/erase_sync.sv
module erase_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("erase_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sh;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh[0] <= 1'b0;
               else        sh[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) sh[i] <= 1'b0;
               else        sh[i] <= sh[i-1];
         end
      end
   endgenerate

   assign q = sh[STAGES-1];
endmodule

// File: rtl/erase_hold_filter.sv
module erase_hold_filter #(
   parameter int TRIG_CYCLES   = 7041,
   parameter int IGNORE_CYCLES = 3200,
   localparam int CNT_W = $clog2(TRIG_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic level,
   output logic fire
);
   generate
      if (TRIG_CYCLES < 2) begin : g_bad_trig
         $error("erase_hold_filter: TRIG_CYCLES must be at least 2");
      end
      if (IGNORE_CYCLES >= TRIG_CYCLES) begin : g_bad_ign
         $error("erase_hold_filter: IGNORE_CYCLES must be below TRIG_CYCLES");
      end
   endgenerate

   localparam logic [CNT_W-1:0] TRIG_V = CNT_W'(TRIG_CYCLES);
   localparam logic [CNT_W-1:0] TRIG_M1 = CNT_W'(TRIG_CYCLES - 1);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt <= '0;
      else if (!level)         cnt <= '0;
      else if (cnt != TRIG_V)  cnt <= cnt + 1'b1;
   end

   assign fire = level && (cnt == TRIG_M1);

   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TRIG_V); // R1
   AST_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
      !level |=> (cnt == '0) && !fire); // R3
   AST_FIRE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire); // R7
endmodule

// File: rtl/nvm_bit_store.sv
module nvm_bit_store
   import erase_pkg::*;
#(
   parameter int N_LOCK   = 16,
   parameter int N_GPNVM  = 3,
   parameter int N_CAL    = 16,
   parameter int IDX_W    = 4,
   parameter logic [N_LOCK-1:0]  LOCK_INIT  = '0,
   parameter logic [N_GPNVM-1:0] GPNVM_INIT = '0,
   parameter logic               SEC_INIT   = 1'b0,
   parameter logic [N_CAL-1:0]   CAL_INIT   = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_en,
   input  logic [2:0]         cmd_op,
   input  logic [IDX_W-1:0]   cmd_idx,
   input  logic               clear_all,
   output logic [N_LOCK-1:0]  lock_bits,
   output logic [N_GPNVM-1:0] gpnvm_bits,
   output logic               security,
   output logic [N_CAL-1:0]   calib_bits
);
   generate
      if (N_GPNVM < 3) begin : g_bad_gp
         $error("nvm_bit_store: at least three general-purpose bits needed");
      end
      if ((1 << IDX_W) < N_LOCK || (1 << IDX_W) < N_GPNVM) begin : g_bad_idx
         $error("nvm_bit_store: IDX_W too narrow");
      end
   endgenerate

   generate
      for (genvar i = 0; i < N_LOCK; i++) begin : g_lock
         logic hit;
         assign hit = cmd_en && (cmd_idx == IDX_W'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  lock_bits[i] <= LOCK_INIT[i];
            else if (clear_all)                          lock_bits[i] <= 1'b0;
            else if (hit && cmd_op == OP_LOCK_SET)       lock_bits[i] <= 1'b1;
            else if (hit && cmd_op == OP_LOCK_CLR)       lock_bits[i] <= 1'b0;
         end
      end
      for (genvar j = 0; j < N_GPNVM; j++) begin : g_gp
         logic hit;
         assign hit = cmd_en && (cmd_idx == IDX_W'(j));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  gpnvm_bits[j] <= GPNVM_INIT[j];
            else if (clear_all)                          gpnvm_bits[j] <= 1'b0;
            else if (hit && cmd_op == OP_GP_SET)         gpnvm_bits[j] <= 1'b1;
            else if (hit && cmd_op == OP_GP_CLR)         gpnvm_bits[j] <= 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   security <= SEC_INIT;
      else if (clear_all)                           security <= 1'b0;
      else if (cmd_en && cmd_op == OP_SEC_SET)      security <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) calib_bits <= CAL_INIT;
   end

   AST_SEC_ONLY_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(security) |-> $past(clear_all)); // R5
endmodule

// File: rtl/erase_nvm_ctrl.sv
module erase_nvm_ctrl
   import erase_pkg::*;
#(
   parameter int TRIG_CYCLES   = 7041,
   parameter int IGNORE_CYCLES = 3200,
   parameter int SYNC_STAGES   = 2,
   parameter int N_LOCK        = 16,
   parameter int N_GPNVM       = 3,
   parameter int N_CAL         = 16,
   parameter logic [N_LOCK-1:0]  LOCK_INIT  = '0,
   parameter logic [N_GPNVM-1:0] GPNVM_INIT = '0,
   parameter logic               SEC_INIT   = 1'b0,
   parameter logic [N_CAL-1:0]   CAL_INIT   = 16'h5A3C,
   localparam int IDX_W = (max_of(N_LOCK, N_GPNVM) > 1) ? $clog2(max_of(N_LOCK, N_GPNVM)) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               erase_pin,
   input  logic               cmd_valid,
   input  logic [2:0]         cmd_op,
   input  logic [IDX_W-1:0]   cmd_idx,
   input  logic               erase_done,
   output logic               erase_req,
   output logic [N_LOCK-1:0]  lock_bits,
   output logic [N_GPNVM-1:0] gpnvm_bits,
   output logic               security,
   output logic [N_CAL-1:0]   calib_bits
);
   logic         pin_s;
   logic         fire;
   logic         clear_all;
   logic         cmd_en;
   erase_state_e state, state_nx;

   erase_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(erase_pin), .q(pin_s));

   erase_hold_filter #(.TRIG_CYCLES(TRIG_CYCLES), .IGNORE_CYCLES(IGNORE_CYCLES)) u_filt (
      .clk(clk), .rst_n(rst_n), .level(pin_s), .fire(fire));

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:     if (fire)       state_nx = ST_REQ;
         ST_REQ:      if (erase_done) state_nx = ST_WAIT_LOW;
         ST_WAIT_LOW: if (!pin_s)     state_nx = ST_IDLE;
         default:                     state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;

   assign erase_req = (state == ST_REQ);
   assign clear_all = erase_req && erase_done;
   assign cmd_en    = cmd_valid && !erase_req;

   nvm_bit_store #(
      .N_LOCK(N_LOCK), .N_GPNVM(N_GPNVM), .N_CAL(N_CAL), .IDX_W(IDX_W),
      .LOCK_INIT(LOCK_INIT), .GPNVM_INIT(GPNVM_INIT), .SEC_INIT(SEC_INIT),
      .CAL_INIT(CAL_INIT)
   ) u_store (
      .clk(clk), .rst_n(rst_n), .cmd_en(cmd_en), .cmd_op(cmd_op),
      .cmd_idx(cmd_idx), .clear_all(clear_all), .lock_bits(lock_bits),
      .gpnvm_bits(gpnvm_bits), .security(security), .calib_bits(calib_bits));

   AST_REQ_NEEDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(erase_req) |-> $past(pin_s)); // R1
   AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req && !erase_done |=> erase_req); // R2
   AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req && erase_done |=> (lock_bits == '0) && (gpnvm_bits == '0) && !security && !erase_req); // R4
   AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req && !erase_done |=> $stable(lock_bits) && $stable(gpnvm_bits) && $stable(security)); // R9
   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_WAIT_LOW) |=> !erase_req); // R7
   AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !erase_req && !cmd_valid |=> $stable(lock_bits) && $stable(gpnvm_bits) && $stable(security)); // R10
endmodule

// File: tb/sim_erase_nvm_ctrl.sv
module sim_erase_nvm_ctrl;
   localparam int TRIG = 12;
   localparam int IGN  = 5;
   localparam int NL   = 8;
   localparam int NG   = 3;
   localparam int NC   = 16;
   localparam logic [NC-1:0] CAL = 16'hA5C3;
   localparam int IW   = 3;

   logic clk = 1'b0, rst_n = 1'b0, pin = 1'b0, cv = 1'b0, done = 1'b0;
   logic [2:0] op = 3'd0;
   logic [IW-1:0] idx = '0;
   logic req, sec;
   logic [NL-1:0] lk;
   logic [NG-1:0] gp;
   logic [NC-1:0] cal;
   int n_chk = 0, n_bad = 0;
   logic [NL-1:0] exp_lk;
   logic [NG-1:0] exp_gp;

   always #4 clk = ~clk;

   erase_nvm_ctrl #(.TRIG_CYCLES(TRIG), .IGNORE_CYCLES(IGN), .N_LOCK(NL),
      .N_GPNVM(NG), .N_CAL(NC), .CAL_INIT(CAL)) u0 (
      .clk(clk), .rst_n(rst_n), .erase_pin(pin), .cmd_valid(cv), .cmd_op(op),
      .cmd_idx(idx), .erase_done(done), .erase_req(req), .lock_bits(lk),
      .gpnvm_bits(gp), .security(sec), .calib_bits(cal));

   task automatic chk(input string tag, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cmd(input logic [2:0] o, input int i);
      @(negedge clk); cv = 1'b1; op = o; idx = IW'(i);
      @(negedge clk); cv = 1'b0; op = 3'd0;
   endtask

   task automatic setup_all();
      for (int i = 0; i < NL; i++) cmd(3'd1, i);
      for (int i = 0; i < NG; i++) cmd(3'd3, i);
      cmd(3'd5, 0);
   endtask

   // hold pin for h sampling edges, return edge index at which req first seen
   task automatic hold(input int h, output int first);
      first = 0;
      @(negedge clk); pin = 1'b1;
      for (int n = 1; n <= TRIG + 4; n++) begin
         @(posedge clk); @(negedge clk);
         if (n == h) pin = 1'b0;
         if (req && first == 0) first = n;
      end
   endtask

   initial begin
      int f;
      #100000000;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int f;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 reset req", req, 0);
      chk("R8 reset lock", lk, 0);
      chk("R8 reset gp", gp, 0);
      chk("R5 reset sec", sec, 0);
      chk("R6 reset calib", cal, CAL);

      // R8 per-index set/clear sweep
      exp_lk = '0; exp_gp = '0;
      for (int i = 0; i < 8; i++) begin
         cmd(3'd1, i); exp_lk[i] = 1'b1;
         chk("R8 lock set", lk, exp_lk);
         cmd(3'd3, i); if (i < NG) exp_gp[i] = 1'b1;
         chk("R8 gp set", gp, exp_gp);
      end
      for (int i = 0; i < 8; i += 2) begin
         cmd(3'd2, i); exp_lk[i] = 1'b0;
         chk("R8 lock clr", lk, exp_lk);
         cmd(3'd4, i); if (i < NG) exp_gp[i] = 1'b0;
         chk("R8 gp clr", gp, exp_gp);
      end
      cmd(3'd0, 1);
      chk("R8 nop lock", lk, exp_lk);

      // R5 security set, clear command ignored
      cmd(3'd5, 0);
      chk("R5 sec set", sec, 1);
      cmd(3'd6, 0);
      chk("R5 sec clr cmd ignored", sec, 1);

      // R10 done while idle
      @(negedge clk); done = 1'b1;
      @(negedge clk); done = 1'b0;
      chk("R10 idle done lock", lk, exp_lk);
      chk("R10 idle done sec", sec, 1);

      // R1/R2 hold-length sweep
      for (int h = 1; h <= TRIG + 2; h++) begin
         setup_all();
         hold(h, f);
         chk($sformatf("R2 R1 latency h=%0d", h), f, (h >= TRIG) ? TRIG + 2 : 0);
         if (h >= TRIG) begin
            chk("R2 req held", req, 1);
            cmd(3'd2, 0);
            chk("R9 blocked lock", lk, {NL{1'b1}});
            cmd(3'd6, 0);
            chk("R9 sec kept", sec, 1);
            @(negedge clk); done = 1'b1;
            @(negedge clk); done = 1'b0;
            chk("R4 req drop", req, 0);
            chk("R4 lock clr", lk, 0);
            chk("R4 gp clr", gp, 0);
            chk("R5 sec clr by erase", sec, 0);
            chk("R6 calib kept", cal, CAL);
         end else begin
            chk("R1 lock kept", lk, {NL{1'b1}});
            chk("R1 sec kept", sec, 1);
         end
         repeat (3) @(negedge clk);
      end

      // R3 split holds
      @(negedge clk); pin = 1'b1;
      repeat (TRIG - 2) @(negedge clk);
      pin = 1'b0;
      @(negedge clk); pin = 1'b1;
      f = 0;
      for (int n = 0; n < TRIG + 1; n++) begin
         @(negedge clk);
         if (n == TRIG - 3) pin = 1'b0;
         if (req) f = 1;
      end
      chk("R3 split holds no req", f, 0);

      // R7 no retrigger while held
      setup_all();
      @(negedge clk); pin = 1'b1;
      repeat (TRIG + 3) @(negedge clk);
      chk("R7 first req", req, 1);
      done = 1'b1;
      @(negedge clk); done = 1'b0;
      chk("R7 cleared", lk, 0);
      f = 0;
      for (int n = 0; n < 3 * TRIG; n++) begin
         @(negedge clk);
         if (req) f = 1;
      end
      chk("R7 no retrigger", f, 0);
      pin = 1'b0;
      repeat (4) @(negedge clk);
      hold(TRIG, f);
      chk("R7 retrigger after low", f, TRIG + 2);
      @(negedge clk); done = 1'b1;
      @(negedge clk); done = 1'b0;
      chk("R6 calib end", cal, CAL);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule